// File: doc/BRIEF.md
# Base-Limit Address Guard

This block sits on the address path between a processor and the memory address register. It holds two privileged registers: a window base and a window length. A request made in user mode passes to memory only when its address falls inside the window that these registers describe. An access outside the window is held back. One cycle later the block raises a trap that carries the faulting address and a cause code. Requests made in kernel mode go to memory untouched.

A build parameter selects one of two variants. The checking variant compares physical addresses against the window and does not change them. The relocating variant treats user addresses as logical offsets from zero and adds the base to each one. The legality test runs on the offset, and a carry out of the address width counts as a violation. The forwarding path is combinational, so a legal request reaches memory in the same cycle it is made. Only the trap output is registered.

Top module: `bound_guard`

## Requirements
- R1: On reset both registers clear to zero and the trap output is low. In the checking variant, user address 0 is then legal and user address 1 traps.
- R2: A write with `cfg_we_i` high and `user_i` low loads `cfg_data_i` into the base when `cfg_sel_i` is 0, or into the length when `cfg_sel_i` is 1. The new value applies from the next cycle.
- R3: A write attempted with `user_i` high changes neither register. In the next cycle it raises `trap_o` with cause 2'b10 (privilege).
- R4: In the checking variant, a user request is legal when base <= address <= base + length, with both ends included. The sum is taken one bit wider than the address, and the address is forwarded unchanged.
- R5: An illegal user request keeps `mem_req_o` low. In the next cycle it raises `trap_o` with cause 2'b01 (range), and `trap_addr_o` equals the requested address.
- R6: A request with `user_i` low always asserts `mem_req_o`, and `mem_addr_o` equals `addr_i`. It never traps.
- R7: In the relocating variant, a user request with address <= length is forwarded with `mem_addr_o` = base + address.
- R8: In the relocating variant, a user address above the length is a range violation. So is a base + address sum that carries out of the address width.
- R9: `mem_req_o` and `mem_addr_o` respond in the same cycle as `req_i`, with no register in the path.
- R10: `trap_o` is high for exactly one cycle per faulting cycle. If a privilege and a range violation occur in the same cycle, the cause is 2'b10. While `trap_o` is low the cause reads 2'b00.
- R11: When `req_i` is low, `mem_req_o` stays low and no range trap is raised, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| addr_i | input | AW | Address from the processor |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 = base, 1 = length |
| cfg_data_i | input | AW | Register write data |
| mem_req_o | output | 1 | Request forwarded to memory |
| mem_addr_o | output | AW | Address sent to memory |
| trap_o | output | 1 | One-cycle violation pulse |
| trap_cause_o | output | 2 | 01 range, 10 privilege, 00 none |
| trap_addr_o | output | AW | Address of the faulting cycle |

## Verification
Two things can happen in the same cycle: a user-mode register write and an out-of-window user request. The bench provokes this by driving `cfg_we_i`, `req_i` and a bad address together with `user_i` high. It then expects a single trap pulse with the privilege cause and the request address. It also confirms that `mem_req_o` stayed low and that a later in-window request still passes, which shows the registers were not touched.

// File: rtl/bound_guard_pkg.sv
package bound_guard_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_RANGE = 2'b01,
        CAUSE_PRIV  = 2'b10
    } cause_e;
endpackage

// File: rtl/bound_guard_regs.sv
module bound_guard_regs #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic          user,
    input  logic [AW-1:0] data,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
    } regs_t;

    regs_t r_d, r_q;

    // Only kernel mode may load the window registers.
    always_comb begin
        r_d = r_q;
        if (we && !user) begin
            if (sel) r_d.limit = data;
            else     r_d.base  = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_q  = r_q.base;
    assign limit_q = r_q.limit;
endmodule

// File: rtl/bound_guard_check.sv
module bound_guard_check #(
    parameter int unsigned AW    = 32,
    parameter bit          RELOC = 1'b0
) (
    input  logic          req,
    input  logic          user,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          fwd,
    output logic [AW-1:0] phys,
    output logic          range_err
);
    logic          in_win;
    logic [AW-1:0] mapped;

    generate
        if (RELOC) begin : g_reloc
            logic [AW:0] sum;
            always_comb begin
                sum    = {1'b0, base} + {1'b0, addr};
                in_win = (addr <= limit) && !sum[AW];
                mapped = sum[AW-1:0];
            end
        end else begin : g_check
            logic [AW:0] top;
            always_comb begin
                top    = {1'b0, base} + {1'b0, limit};
                in_win = (addr >= base) && ({1'b0, addr} <= top);
                mapped = addr;
            end
        end
    endgenerate

    always_comb begin
        if (!user) begin
            fwd       = req;
            phys      = addr;
            range_err = 1'b0;
        end else begin
            fwd       = req && in_win;
            phys      = mapped;
            range_err = req && !in_win;
        end
    end
endmodule

// File: rtl/bound_guard_trap.sv
module bound_guard_trap
    import bound_guard_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          range_err,
    input  logic          priv_err,
    input  logic [AW-1:0] addr,
    output logic          trap,
    output logic [1:0]    cause,
    output logic [AW-1:0] trap_addr
);
    typedef struct packed {
        logic          hit;
        cause_e        why;
        logic [AW-1:0] where;
    } trap_t;

    trap_t t_d, t_q;

    // Privilege faults take precedence over range faults.
    always_comb begin
        t_d     = t_q;
        t_d.hit = range_err || priv_err;
        if (priv_err)       t_d.why = CAUSE_PRIV;
        else if (range_err) t_d.why = CAUSE_RANGE;
        else                t_d.why = CAUSE_NONE;
        if (range_err || priv_err) t_d.where = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{hit: 1'b0, why: CAUSE_NONE, where: '0};
        else        t_q <= t_d;
    end

    assign trap      = t_q.hit;
    assign cause     = t_q.why;
    assign trap_addr = t_q.where;
endmodule

// File: rtl/bound_guard.sv
module bound_guard #(
    parameter int unsigned AW    = 32,
    parameter bit          RELOC = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          user_i,
    input  logic [AW-1:0] addr_i,
    input  logic          cfg_we_i,
    input  logic          cfg_sel_i,
    input  logic [AW-1:0] cfg_data_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          trap_o,
    output logic [1:0]    trap_cause_o,
    output logic [AW-1:0] trap_addr_o
);
    logic [AW-1:0] base_w;
    logic [AW-1:0] limit_w;
    logic          range_w;
    logic          priv_w;

    assign priv_w = cfg_we_i && user_i;

    bound_guard_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we_i),
        .sel     (cfg_sel_i),
        .user    (user_i),
        .data    (cfg_data_i),
        .base_q  (base_w),
        .limit_q (limit_w)
    );

    bound_guard_check #(.AW(AW), .RELOC(RELOC)) u_check (
        .req       (req_i),
        .user      (user_i),
        .addr      (addr_i),
        .base      (base_w),
        .limit     (limit_w),
        .fwd       (mem_req_o),
        .phys      (mem_addr_o),
        .range_err (range_w)
    );

    bound_guard_trap #(.AW(AW)) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_err (range_w),
        .priv_err  (priv_w),
        .addr      (addr_i),
        .trap      (trap_o),
        .cause     (trap_cause_o),
        .trap_addr (trap_addr_o)
    );
endmodule

// File: rtl/bound_guard_chk.sv
module bound_guard_chk #(
    parameter int unsigned AW    = 32,
    parameter bit          RELOC = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          user_i,
    input logic [AW-1:0] addr_i,
    input logic          cfg_we_i,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          trap_o,
    input logic [1:0]    trap_cause_o,
    input logic [AW-1:0] base,
    input logic [AW-1:0] limit
);
    p_kernel_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !user_i) |-> (mem_req_o && mem_addr_o == addr_i));

    p_user_write_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && user_i) |=> ($stable(base) && $stable(limit)));

    p_priv_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && user_i) |=> (trap_o && trap_cause_o == 2'b10));

    p_range_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_cause_o == 2'b01) |-> $past(req_i && user_i && !mem_req_o));

    p_no_req_no_fwd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> !mem_req_o);

    p_cause_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o ? (trap_cause_o != 2'b00) : (trap_cause_o == 2'b00));

    p_reloc_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (RELOC && mem_req_o && user_i) |-> (addr_i <= limit));
endmodule

bind bound_guard bound_guard_chk #(.AW(AW), .RELOC(RELOC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .user_i       (user_i),
    .addr_i       (addr_i),
    .cfg_we_i     (cfg_we_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .trap_o       (trap_o),
    .trap_cause_o (trap_cause_o),
    .base         (base_w),
    .limit        (limit_w)
);

// File: tb/bound_guard_tb.sv
module bound_guard_tb;
    localparam int unsigned AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, user = 1'b0, we = 1'b0, sel = 1'b0;
    logic [AW-1:0] addr = '0, data = '0;

    logic          mreq0, mreq1, trap0, trap1;
    logic [AW-1:0] maddr0, maddr1, taddr0, taddr1;
    logic [1:0]    cause0, cause1;

    always #2.5 clk = ~clk;

    bound_guard #(.AW(AW), .RELOC(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .user_i(user), .addr_i(addr),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(data),
        .mem_req_o(mreq0), .mem_addr_o(maddr0), .trap_o(trap0),
        .trap_cause_o(cause0), .trap_addr_o(taddr0)
    );

    bound_guard #(.AW(AW), .RELOC(1'b1)) u_dut_rl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .user_i(user), .addr_i(addr),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(data),
        .mem_req_o(mreq1), .mem_addr_o(maddr1), .trap_o(trap1),
        .trap_cause_o(cause1), .trap_addr_o(taddr1)
    );

    typedef struct {
        bit            t0;
        logic [1:0]    c0;
        bit            t1;
        logic [1:0]    c1;
        logic [AW-1:0] a;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;
    logic [AW-1:0] m_base = '0, m_limit = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input bit rl, input bit r, input bit u,
                                  input logic [AW-1:0] a, output bit fwd,
                                  output logic [AW-1:0] ph, output bit rng);
        logic [AW:0] s;
        bit ok;
        fwd = 1'b0; ph = a; rng = 1'b0;
        if (!r) return;
        if (!u) begin fwd = 1'b1; return; end
        if (!rl) begin
            s  = {1'b0, m_base} + {1'b0, m_limit};
            ok = (a >= m_base) && ({1'b0, a} <= s);
        end else begin
            s  = {1'b0, m_base} + {1'b0, a};
            ok = (a <= m_limit) && !s[AW];
            ph = s[AW-1:0];
        end
        fwd = ok; rng = !ok;
    endfunction

    // Driver: applies one cycle of stimulus, checks the combinational path,
    // and pushes the expected trap outcome for the monitor.
    task automatic apply(input bit r, input bit u, input bit w, input bit s,
                         input logic [AW-1:0] a, input logic [AW-1:0] d,
                         input string tag);
        bit f0, f1, g0, g1, priv;
        logic [AW-1:0] p0, p1;
        exp_t e;
        @(negedge clk);
        req = r; user = u; we = w; sel = s; addr = a; data = d;
        #1;
        model(1'b0, r, u, a, f0, p0, g0);
        model(1'b1, r, u, a, f1, p1, g1);
        chk(mreq0 == f0, tag, "chk mem_req", mreq0, f0);
        chk(mreq1 == f1, tag, "rel mem_req", mreq1, f1);
        if (f0) chk(maddr0 == p0, tag, "chk mem_addr", maddr0, p0);
        if (f1) chk(maddr1 == p1, tag, "rel mem_addr", maddr1, p1);
        priv = w && u;
        e.t0 = priv || g0;
        e.c0 = priv ? 2'b10 : (g0 ? 2'b01 : 2'b00);
        e.t1 = priv || g1;
        e.c1 = priv ? 2'b10 : (g1 ? 2'b01 : 2'b00);
        e.a = a;
        e.tag = tag;
        sb.push_back(e);
        if (w && !u) begin
            if (s) m_limit = d;
            else   m_base  = d;
        end
    endtask

    task automatic idle(input string tag);
        apply(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, tag);
    endtask

    // Monitor: compares the registered trap outputs after each edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(trap0 == e.t0, e.tag, "chk trap", trap0, e.t0);
                chk(trap1 == e.t1, e.tag, "rel trap", trap1, e.t1);
                chk(cause0 == e.c0, e.tag, "chk cause", cause0, e.c0);
                chk(cause1 == e.c1, e.tag, "rel cause", cause1, e.c1);
                if (e.t0) chk(taddr0 == e.a, e.tag, "chk trap_addr", taddr0, e.a);
                if (e.t1) chk(taddr1 == e.a, e.tag, "rel trap_addr", taddr1, e.a);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!trap0 && !trap1, "R1", "trap after reset", trap0 | trap1, 0);
        // R1: zero window -> address 0 legal, 1 illegal
        apply(1, 1, 0, 0, 16'h0000, '0, "R1");
        apply(1, 1, 0, 0, 16'h0001, '0, "R1");
        // R2: kernel loads base 3000, length 1000
        apply(0, 0, 1, 0, '0, 16'd3000, "R2");
        apply(0, 0, 1, 1, '0, 16'd1000, "R2");
        // R4/R5/R7/R8: edges of the window in both variants
        apply(1, 1, 0, 0, 16'd3000, '0, "R4");
        apply(1, 1, 0, 0, 16'd4000, '0, "R4");
        apply(1, 1, 0, 0, 16'd2999, '0, "R5");
        apply(1, 1, 0, 0, 16'd4001, '0, "R5");
        apply(1, 1, 0, 0, 16'd346, '0, "R7");
        apply(1, 1, 0, 0, 16'd1000, '0, "R7");
        apply(1, 1, 0, 0, 16'd1001, '0, "R8");
        // R6: kernel bypass on an address outside the window
        apply(1, 0, 0, 0, 16'd100, '0, "R6");
        // R3: user write is refused; window still intact afterwards
        apply(0, 1, 1, 0, '0, 16'h1234, "R3");
        apply(1, 1, 0, 0, 16'd3500, '0, "R3");
        apply(0, 1, 1, 1, '0, 16'h0001, "R3");
        apply(1, 1, 0, 0, 16'd999, '0, "R3");
        // R10: privilege and range fault together -> privilege cause
        apply(1, 1, 1, 0, 16'd5000, 16'h0002, "R10");
        apply(1, 1, 0, 0, 16'd3001, '0, "R10");
        // R11: no request, bad address -> nothing
        apply(0, 1, 0, 0, 16'hFFFF, '0, "R11");
        // R10: back-to-back faults give back-to-back pulses then low
        apply(1, 1, 0, 0, 16'd6000, '0, "R10");
        apply(1, 1, 0, 0, 16'd6001, '0, "R10");
        idle("R10");
        // R8: carry out of the address width in the relocating variant
        apply(0, 0, 1, 0, '0, 16'hF000, "R2");
        apply(0, 0, 1, 1, '0, 16'h2000, "R2");
        apply(1, 1, 0, 0, 16'h0FFF, '0, "R8");
        apply(1, 1, 0, 0, 16'h1000, '0, "R8");
        apply(1, 1, 0, 0, 16'hFFFF, '0, "R4");
        // R9: same-cycle forwarding (checked at #1 inside apply)
        apply(1, 1, 0, 0, 16'hF800, '0, "R9");
        idle("R9");
        idle("R9");
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule